// File: doc/BRIEF.md
# Multichannel ADC Conversion Controller

This block sits on a simple register bus and runs single conversions on an external analog-to-digital converter. Software picks an analog input and a sampling-time code in the second control word, then writes the start bit of the first control word. The controller waits out the sampling time, pulses a start strobe to the converter with the channel number, waits for the converter's done strobe, and latches the 12-bit result into a data register. At the same time it sets a sticky completion flag. The flag raises the interrupt line when its enable bit is set, and software clears it by writing 1.

A soft-reset request in the first control word starts a self-timed sequence. For a fixed number of cycles every register except the version word is held at its default. Any conversion in progress is dropped. After that the request bit reads 0 again. Channels 0 to NUM_CH-1 are valid. A start request naming any higher channel is discarded.

Top module: `adc_conv_ctrl`

Register byte offsets: 0x00 control-1, 0x04 control-2, 0x08 status, 0x0C result, 0x10 interrupt enable, 0x14 interrupt flag, 0x20 version.

## Requirements
- R1: After rst_ni is released, every register reads 0 except the version register, which reads the VERSION parameter. irq_o and conv_start_o are 0.
- R2: Control-2 holds the channel in bits 3:0, the sampling code in bits 6:4, and three option bits at 8, 9 and 10. It reads back `write & 0x77F`, and all other bits read 0.
- R3: Writing 1 to control-1 bit 0 while idle, with a valid channel, causes exactly one single-cycle conv_start_o pulse with conv_ch_o equal to the channel. Status bit 0 reads 1 from the accepted write until the done strobe.
- R4: With sampling code c, conv_start_o is high in the cycle that follows the 4*c-th clock edge after the edge that accepts the start write.
- R5: When conv_done_i is high while the controller waits for a result, the register at 0x0C takes conv_data_i, replacing any earlier value. Bit 0 at 0x14 becomes 1.
- R6: A start request with channel code 10 or higher produces no conv_start_o pulse, leaves status bit 0 at 0, and leaves bit 0 at 0x14 at 0.
- R7: A start write during a conversion is ignored. A control-2 write during a conversion does not change conv_ch_o for that conversion.
- R8: irq_o is high exactly when bit 0 at 0x10 and bit 0 at 0x14 are both 1. The flag at 0x14 stays set until a write with bit 0 = 1 clears it. A write with bit 0 = 0 leaves it set.
- R9: Writing 1 to control-1 bit 2 makes that bit read 1 for RST_CYCLES cycles, then 0. Afterwards the registers are back at their defaults. Writes made during those cycles are lost. A conversion in flight is abandoned, so a later done strobe changes nothing.
- R10: The version register at 0x20 ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 6 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed register |
| irq_o | output | 1 | Conversion-done interrupt |
| conv_start_o | output | 1 | Single-cycle start strobe to the converter |
| conv_ch_o | output | 4 | Channel number for the converter |
| conv_done_i | input | 1 | Result-valid strobe from the converter |
| conv_data_i | input | RES_W | Converter result |

## Verification
The bench builds the block with NUM_CH=10 and RST_CYCLES=6. It also overrides VERSION with a distinctive value. With 4-bit channel codes, codes 10 to 15 give the out-of-range case, and a six-cycle reset window leaves room to try writes while the reset is active. Random trials cover every sampling code from 0 to 7, so the measured delay runs from zero to 28 cycles. Random converter latencies and result values show that a new result replaces the old one in the data register.

// File: rtl/adc_conv_pkg.sv
package adc_conv_pkg;
  localparam int AW   = 6;
  localparam int DW   = 32;
  localparam int CH_W = 4;
  localparam int CT_W = 3;

  localparam logic [AW-1:0] OFS_CTRL1 = 6'h00;
  localparam logic [AW-1:0] OFS_CTRL2 = 6'h04;
  localparam logic [AW-1:0] OFS_STAT  = 6'h08;
  localparam logic [AW-1:0] OFS_DATA  = 6'h0C;
  localparam logic [AW-1:0] OFS_IEN   = 6'h10;
  localparam logic [AW-1:0] OFS_IST   = 6'h14;
  localparam logic [AW-1:0] OFS_VER   = 6'h20;

  typedef enum logic [1:0] {SQ_IDLE, SQ_SAMPLE, SQ_FIRE, SQ_WAIT} seq_state_e;
endpackage

// File: rtl/adc_conv_srst.sv
module adc_conv_srst #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic active_o
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (trig_i && cnt_q == '0)  cnt_q <= CW'(RST_CYCLES);
    else if (cnt_q != '0)            cnt_q <= cnt_q - CW'(1);
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_conv_pkg::*;
#(
  parameter int NUM_CH   = 10,
  parameter int CT_SCALE = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            go_i,
  input  logic [CH_W-1:0] ch_i,
  input  logic [CT_W-1:0] ctime_i,
  input  logic            conv_done_i,
  output logic            busy_o,
  output logic            fire_o,
  output logic [CH_W-1:0] ch_o,
  output logic            done_o
);
  localparam int SW = CT_W + $clog2(CT_SCALE) + 1;

  seq_state_e      st_q;
  logic [SW-1:0]   cnt_q;
  logic [CH_W-1:0] ch_q;
  logic            ch_ok;

  assign ch_ok = (32'(ch_i) < NUM_CH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
      ch_q  <= '0;
    end else if (clr_i) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: if (go_i && ch_ok) begin
          ch_q <= ch_i;
          if (ctime_i == '0) st_q <= SQ_FIRE;
          else begin
            st_q  <= SQ_SAMPLE;
            cnt_q <= SW'(ctime_i) * SW'(CT_SCALE) - SW'(1);
          end
        end
        SQ_SAMPLE: begin
          if (cnt_q == '0) st_q <= SQ_FIRE;
          else             cnt_q <= cnt_q - SW'(1);
        end
        SQ_FIRE: st_q <= SQ_WAIT;
        SQ_WAIT: if (conv_done_i) st_q <= SQ_IDLE;
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != SQ_IDLE);
  assign fire_o = (st_q == SQ_FIRE);
  assign ch_o   = ch_q;
  assign done_o = (st_q == SQ_WAIT) && conv_done_i && !clr_i;
endmodule

// File: rtl/adc_conv_regs.sv
module adc_conv_regs
  import adc_conv_pkg::*;
#(
  parameter int          RES_W   = 12,
  parameter logic [31:0] VERSION = 32'h0002_0001
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             busy_i,
  input  logic             done_i,
  input  logic [RES_W-1:0] result_i,
  output logic [DW-1:0]    rdata_o,
  output logic [CH_W-1:0]  ch_o,
  output logic [CT_W-1:0]  ctime_o,
  output logic             ist_o,
  output logic             go_o,
  output logic             srst_trig_o,
  output logic             irq_o
);
  logic [CH_W-1:0]  ch_q;
  logic [CT_W-1:0]  ct_q;
  logic [2:0]       opt_q;
  logic [RES_W-1:0] data_q;
  logic             ien_q, ist_q, wr;
  logic             unused_wbits;

  assign wr           = req_i && we_i && !clr_i;
  assign unused_wbits = ^{wdata_i[31:11], wdata_i[7]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_q <= '0; ct_q <= '0; opt_q <= '0; data_q <= '0; ien_q <= 1'b0; ist_q <= 1'b0;
    end else if (clr_i) begin
      ch_q <= '0; ct_q <= '0; opt_q <= '0; data_q <= '0; ien_q <= 1'b0; ist_q <= 1'b0;
    end else begin
      if (wr && addr_i == OFS_CTRL2) begin
        ch_q  <= wdata_i[3:0];
        ct_q  <= wdata_i[6:4];
        opt_q <= wdata_i[10:8];
      end
      if (wr && addr_i == OFS_IEN) ien_q <= wdata_i[0];
      if (done_i) data_q <= result_i;
      // a new completion outranks a simultaneous clear
      if (done_i)                                       ist_q <= 1'b1;
      else if (wr && addr_i == OFS_IST && wdata_i[0])   ist_q <= 1'b0;
    end
  end

  assign go_o        = wr && addr_i == OFS_CTRL1 && wdata_i[0] && !wdata_i[2];
  assign srst_trig_o = wr && addr_i == OFS_CTRL1 && wdata_i[2];

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_CTRL1: rdata_o[2]       = clr_i;
      OFS_CTRL2: rdata_o[10:0]    = {opt_q, 1'b0, ct_q, ch_q};
      OFS_STAT:  rdata_o[0]       = busy_i;
      OFS_DATA:  rdata_o[RES_W-1:0] = data_q;
      OFS_IEN:   rdata_o[0]       = ien_q;
      OFS_IST:   rdata_o[0]       = ist_q;
      OFS_VER:   rdata_o          = VERSION;
      default:   rdata_o          = '0;
    endcase
  end

  assign ch_o    = ch_q;
  assign ctime_o = ct_q;
  assign ist_o   = ist_q;
  assign irq_o   = ien_q & ist_q;
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_conv_pkg::*;
#(
  parameter int          NUM_CH     = 10,
  parameter int          RES_W      = 12,
  parameter int          CT_SCALE   = 4,
  parameter int          RST_CYCLES = 4,
  parameter logic [31:0] VERSION    = 32'h0002_0001
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [5:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             irq_o,
  output logic             conv_start_o,
  output logic [3:0]       conv_ch_o,
  input  logic             conv_done_i,
  input  logic [RES_W-1:0] conv_data_i
);
  logic            srst_w, srst_trig_w, go_w, busy_w, done_w, ist_w;
  logic [CH_W-1:0] ch_w;
  logic [CT_W-1:0] ct_w;

  adc_conv_srst #(.RST_CYCLES(RST_CYCLES)) u_srst (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(srst_trig_w), .active_o(srst_w)
  );

  adc_conv_regs #(.RES_W(RES_W), .VERSION(VERSION)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(srst_w),
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .busy_i(busy_w), .done_i(done_w), .result_i(conv_data_i),
    .rdata_o(rdata_o), .ch_o(ch_w), .ctime_o(ct_w), .ist_o(ist_w),
    .go_o(go_w), .srst_trig_o(srst_trig_w), .irq_o(irq_o)
  );

  adc_conv_seq #(.NUM_CH(NUM_CH), .CT_SCALE(CT_SCALE)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(srst_w), .go_i(go_w),
    .ch_i(ch_w), .ctime_i(ct_w), .conv_done_i(conv_done_i),
    .busy_o(busy_w), .fire_o(conv_start_o), .ch_o(conv_ch_o), .done_o(done_w)
  );
endmodule

// File: rtl/adc_conv_chk.sv
module adc_conv_chk #(
  parameter int NUM_CH = 10
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [5:0]  addr_i,
  input logic [31:0] wdata_i,
  input logic        irq_o,
  input logic        conv_start_o,
  input logic        busy_i,
  input logic        srst_i,
  input logic        done_i,
  input logic        ist_i,
  input logic [3:0]  ch_i
);
  // R3
  fire_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  // R6
  bad_ch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 6'h00 && wdata_i[0] && !wdata_i[2] &&
     !busy_i && !srst_i && 32'(ch_i) >= NUM_CH) |=> !busy_i);

  // R8
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 6'h14 && wdata_i[0] && !done_i) |=> !irq_o);

  // R9
  srst_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> !conv_start_o);

  // R5
  done_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> ist_i);

  // R7
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !srst_i && !done_i) |=> busy_i);
endmodule

bind adc_conv_ctrl adc_conv_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .irq_o(irq_o),
  .conv_start_o(conv_start_o), .busy_i(busy_w), .srst_i(srst_w),
  .done_i(done_w), .ist_i(ist_w), .ch_i(ch_w)
);

// File: tb/tb_adc_conv_ctrl.sv
`timescale 1ns/1ps
module tb_adc_conv_ctrl;
  localparam int          NCH = 10;
  localparam int          RST = 6;
  localparam logic [31:0] VER = 32'hA502_0201;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, conv_start_o, conv_done_i = 1'b0;
  logic [3:0]  conv_ch_o;
  logic [11:0] conv_data_i = '0;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  adc_conv_ctrl #(.NUM_CH(NCH), .RES_W(12), .CT_SCALE(4), .RST_CYCLES(RST), .VERSION(VER)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .conv_start_o(conv_start_o),
    .conv_ch_o(conv_ch_o), .conv_done_i(conv_done_i), .conv_data_i(conv_data_i)
  );

  function automatic int exp_delay(input int ct); return ct * 4; endfunction
  function automatic bit exp_valid(input int ch); return ch < NCH; endfunction
  function automatic logic [31:0] exp_ctrl2(input logic [31:0] w); return w & 32'h0000_077F; endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr_i = a;
    #0.5;
    d = rdata_o;
  endtask

  task automatic done_pulse(input logic [11:0] v);
    @(negedge clk_i);
    conv_done_i = 1'b1; conv_data_i = v;
    @(negedge clk_i);
    conv_done_i = 1'b0;
  endtask

  task automatic conv_run(input int ch, input int ct, input logic [11:0] v, input int lat);
    logic [31:0] r;
    int n;
    wr(6'h04, {25'd0, 3'(ct), 4'(ch)});
    wr(6'h00, 32'h1);
    if (exp_valid(ch)) begin
      n = 0;
      while (!conv_start_o && n < 100) begin @(negedge clk_i); n++; end
      chk("R4 start delay", 32'(n), 32'(exp_delay(ct)));
      chk("R3 channel", 32'(conv_ch_o), 32'(ch));
      @(negedge clk_i);
      chk("R3 pulse width", 32'(conv_start_o), 32'd0);
      rd(6'h08, r); chk("R3 busy", r, 32'd1);
      for (int i = 1; i < lat; i++) @(negedge clk_i);
      done_pulse(v);
      rd(6'h0C, r); chk("R5 data", r, {20'd0, v});
      rd(6'h14, r); chk("R5 flag", r, 32'd1);
      rd(6'h08, r); chk("R3 idle after done", r, 32'd0);
      wr(6'h14, 32'h1);
      rd(6'h14, r); chk("R8 clear", r, 32'd0);
    end else begin
      n = 0;
      for (int i = 0; i < 40; i++) begin
        if (conv_start_o) n++;
        @(negedge clk_i);
      end
      chk("R6 no start", 32'(n), 32'd0);
      rd(6'h08, r); chk("R6 not busy", r, 32'd0);
      rd(6'h14, r); chk("R6 no flag", r, 32'd0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int n, p;
    logic [3:0] seen_ch;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(6'h00, r); chk("R1 ctrl1", r, 0);
    rd(6'h04, r); chk("R1 ctrl2", r, 0);
    rd(6'h08, r); chk("R1 status", r, 0);
    rd(6'h0C, r); chk("R1 data", r, 0);
    rd(6'h10, r); chk("R1 ien", r, 0);
    rd(6'h14, r); chk("R1 ist", r, 0);
    rd(6'h20, r); chk("R1 version", r, VER);
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 start", 32'(conv_start_o), 0);

    // R2 field mask
    wr(6'h04, 32'hFFFF_FFFF);
    rd(6'h04, r); chk("R2 mask all", r, exp_ctrl2(32'hFFFF_FFFF));
    wr(6'h04, 32'h0000_05A3);
    rd(6'h04, r); chk("R2 pattern", r, exp_ctrl2(32'h0000_05A3));

    // R10 version write ignored
    wr(6'h20, 32'h0);
    rd(6'h20, r); chk("R10 version", r, VER);

    // R4 R6 corner codes
    conv_run(0, 0, 12'hFFF, 1);
    conv_run(9, 7, 12'h001, 3);
    conv_run(10, 2, 12'h0, 1);
    conv_run(15, 0, 12'h0, 1);

    // random trials
    for (int t = 0; t < 24; t++) begin
      int ch, ct, lat;
      logic [11:0] v;
      ch  = int'($urandom_range(0, 15));
      ct  = int'($urandom_range(0, 7));
      lat = int'($urandom_range(1, 6));
      v   = 12'($urandom);
      conv_run(ch, ct, v, lat);
    end

    // R7 start and channel change while busy
    wr(6'h04, 32'h0000_0023);
    wr(6'h00, 32'h1);
    wr(6'h00, 32'h1);
    wr(6'h04, 32'h0000_0005);
    p = 0; seen_ch = '0;
    for (int i = 0; i < 20; i++) begin
      if (conv_start_o) begin p++; seen_ch = conv_ch_o; end
      @(negedge clk_i);
    end
    chk("R7 single pulse", 32'(p), 1);
    chk("R7 channel held", 32'(seen_ch), 3);
    done_pulse(12'h5A5);
    rd(6'h0C, r); chk("R7 result", r, 32'h5A5);

    // R8 gating and sticky flag
    wr(6'h10, 32'h1);
    chk("R8 irq set", 32'(irq_o), 1);
    wr(6'h14, 32'h0);
    chk("R8 write zero keeps", 32'(irq_o), 1);
    wr(6'h10, 32'h0);
    chk("R8 gated off", 32'(irq_o), 0);
    rd(6'h14, r); chk("R8 flag sticky", r, 1);
    wr(6'h10, 32'h1);
    wr(6'h14, 32'h1);
    chk("R8 cleared", 32'(irq_o), 0);

    // R9 soft reset aborts conversion
    wr(6'h04, 32'h0000_0705);
    wr(6'h00, 32'h1);
    n = 0;
    while (!conv_start_o && n < 50) begin @(negedge clk_i); n++; end
    @(negedge clk_i);
    wr(6'h00, 32'h4);
    n = 0;
    rd(6'h00, r);
    while (r[2] && n < 100) begin n++; @(negedge clk_i); rd(6'h00, r); end
    chk("R9 reset length", 32'(n), RST);
    rd(6'h04, r); chk("R9 ctrl2 default", r, 0);
    rd(6'h10, r); chk("R9 ien default", r, 0);
    rd(6'h0C, r); chk("R9 data default", r, 0);
    rd(6'h08, r); chk("R9 idle", r, 0);
    done_pulse(12'hABC);
    rd(6'h14, r); chk("R9 late done ignored", r, 0);
    rd(6'h0C, r); chk("R9 late data ignored", r, 0);
    rd(6'h20, r); chk("R9 version kept", r, VER);

    // R9 writes during reset lost
    wr(6'h00, 32'h4);
    wr(6'h10, 32'h1);
    wr(6'h04, 32'h0000_0012);
    repeat (RST + 2) @(negedge clk_i);
    rd(6'h10, r); chk("R9 ien write lost", r, 0);
    rd(6'h04, r); chk("R9 ctrl2 write lost", r, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule